// File: doc/BRIEF.md
# Configurable access-type register cell

This block is a single slot of a memory-mapped register bank. A bus front end, which is not part of this block, decodes the address and the handshake. It hands the cell three things: a one-cycle write strobe, a one-cycle read strobe, and a flag saying the address selects this slot. The cell returns its read value to the bank's read mux. Toward the internal logic it presents the held value. It can also issue one-cycle pulses that report host reads and host writes. An update port lets the internal logic load a new value.

A parameter picks who owns the value. In host types (read-write, write-only, and write-only with a write pulse), host writes change the value and internal logic cannot. In logic-owned types, the value changes only through the update strobe. Host reads and host writes can be reported with pulses, and a reported host write also comes with a registered copy of its data. In the constant type, the value is a parameter and every write is ignored. One cell design therefore covers every slot of a bank, and each slot sets its own reset value.

Top module: `acc_reg_cell`

## Requirements
- R1: Host read-write type: a write strobe with `addr_hit` stores `wr_data` at the next clock edge. From then on, `value_out` and `rd_value` both show the stored word.
- R2: A write strobe with `addr_hit` low changes no stored value, raises no pulse and leaves `wr_data_q` unchanged.
- R3: Host write-only types: a hit write stores the data on `value_out` at the next edge. `rd_value` is all zeros at all times.
- R4: The write-only-with-pulse type and the logic-owned types with write notification raise `wr_pulse` for exactly the one cycle after each hit write. All other types keep `wr_pulse` low.
- R5: Logic-owned types: `value_out` changes only at an edge where `upd_stb` was high, and it then takes `upd_data`. `rd_value` equals `value_out`.
- R6: Logic-owned types with read notification raise `rd_pulse` for the one cycle after each read strobe with `addr_hit`. All other types keep `rd_pulse` low.
- R7: Logic-owned types with write notification: a hit write leaves `value_out` unchanged. `wr_data_q` takes the write data at the same edge where `wr_pulse` rises.
- R8: Constant type: `value_out` and `rd_value` always equal `CONST_VAL`, whatever writes or updates arrive.
- R9: An edge with the active-high synchronous `rst` high loads `RST_VAL` into host and logic-owned values. It drives `rd_pulse` and `wr_pulse` low and clears `wr_data_q` to zero.
- R10: When `upd_stb` and a hit host write reach a logic-owned type in the same cycle, `upd_data` is stored. The write pulse and the `wr_data_q` capture still happen.
- R11: Host types ignore `upd_stb`: it changes neither `value_out` nor `rd_value`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_stb | input | 1 | One-cycle host write strobe from the front end |
| rd_stb | input | 1 | One-cycle host read strobe from the front end |
| addr_hit | input | 1 | High when the current address selects this cell |
| wr_data | input | DATA_W | Host write data |
| upd_stb | input | 1 | Internal-logic load strobe (used by logic-owned types) |
| upd_data | input | DATA_W | Value loaded on `upd_stb` |
| rd_value | output | DATA_W | Word offered to the bank read mux (combinational from the held value) |
| value_out | output | DATA_W | Held value presented to internal logic |
| rd_pulse | output | 1 | One-cycle host read notification |
| wr_pulse | output | 1 | One-cycle host write notification |
| wr_data_q | output | DATA_W | Registered copy of the last notified host write data |

## Verification
The functions that can fall in the same cycle are an internal update and a host write to a logic-owned cell. The bench raises `upd_stb` and a hit write strobe in the same cycle, with different data words. It judges the result one edge later: `value_out` must hold the update word, while `wr_pulse` is high and `wr_data_q` holds the host word. The same overlapping cycle also reaches the host-owned cells, which must take the host word and disregard the update.

// File: rtl/acc_reg_cell_pkg.sv
package acc_reg_cell_pkg;

    typedef enum logic [2:0] {
        ACC_HOST_RW       = 3'd0,
        ACC_HOST_WO       = 3'd1,
        ACC_HOST_WO_WNTF  = 3'd2,
        ACC_LOGIC_RO      = 3'd3,
        ACC_LOGIC_RO_RNTF = 3'd4,
        ACC_LOGIC_RO_WNTF = 3'd5,
        ACC_LOGIC_RO_RWNTF= 3'd6,
        ACC_CONST         = 3'd7
    } acc_kind_e;

    typedef enum logic [1:0] {
        OWN_HOST  = 2'd0,
        OWN_LOGIC = 2'd1,
        OWN_PARAM = 2'd2
    } owner_e;

    typedef struct packed {
        logic wr;
        logic rd;
    } hit_t;

    function automatic owner_e acc_owner(acc_kind_e k);
        case (k)
            ACC_HOST_RW, ACC_HOST_WO, ACC_HOST_WO_WNTF: return OWN_HOST;
            ACC_CONST:                                  return OWN_PARAM;
            default:                                    return OWN_LOGIC;
        endcase
    endfunction

    function automatic bit acc_readable(acc_kind_e k);
        return !(k == ACC_HOST_WO || k == ACC_HOST_WO_WNTF);
    endfunction

    function automatic bit acc_rd_notify(acc_kind_e k);
        return (k == ACC_LOGIC_RO_RNTF || k == ACC_LOGIC_RO_RWNTF);
    endfunction

    function automatic bit acc_wr_notify(acc_kind_e k);
        return (k == ACC_HOST_WO_WNTF || k == ACC_LOGIC_RO_WNTF ||
                k == ACC_LOGIC_RO_RWNTF);
    endfunction

endpackage

// File: rtl/acc_reg_store.sv
module acc_reg_store
    import acc_reg_cell_pkg::*;
#(
    parameter int          DATA_W    = 32,
    parameter acc_kind_e   ACC       = ACC_HOST_RW,
    parameter logic [DATA_W-1:0] RST_VAL   = '0,
    parameter logic [DATA_W-1:0] CONST_VAL = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_we,
    input  logic [DATA_W-1:0] host_data,
    input  logic              upd_stb,
    input  logic [DATA_W-1:0] upd_data,
    output logic [DATA_W-1:0] value
);

    localparam owner_e OWNER = acc_owner(ACC);

    generate
        if (OWNER == OWN_HOST) begin : g_host
            logic [DATA_W-1:0] held_q;
            logic unused_upd;
            assign unused_upd = upd_stb ^ (^upd_data);
            always_ff @(posedge clk) begin
                if (rst) begin
                    held_q <= RST_VAL;
                end else if (host_we) begin
                    held_q <= host_data;
                end
            end
            assign value = held_q;
        end else if (OWNER == OWN_LOGIC) begin : g_logic
            logic [DATA_W-1:0] held_q;
            logic unused_host;
            assign unused_host = host_we ^ (^host_data);
            always_ff @(posedge clk) begin
                if (rst) begin
                    held_q <= RST_VAL;
                end else if (upd_stb) begin
                    held_q <= upd_data;
                end
            end
            assign value = held_q;
        end else begin : g_param
            logic unused_all;
            assign unused_all = clk ^ rst ^ host_we ^ (^host_data) ^
                                upd_stb ^ (^upd_data);
            assign value = CONST_VAL;
        end
    endgenerate

endmodule

// File: rtl/acc_reg_notify.sv
module acc_reg_notify
    import acc_reg_cell_pkg::*;
#(
    parameter int        DATA_W = 32,
    parameter acc_kind_e ACC    = ACC_HOST_RW
) (
    input  logic              clk,
    input  logic              rst,
    input  hit_t              hit,
    input  logic [DATA_W-1:0] host_data,
    output logic              rd_pulse,
    output logic              wr_pulse,
    output logic [DATA_W-1:0] wr_data_q
);

    localparam bit RD_NTF = acc_rd_notify(ACC);
    localparam bit WR_NTF = acc_wr_notify(ACC);

    generate
        if (RD_NTF) begin : g_rd
            logic rd_q;
            always_ff @(posedge clk) begin
                if (rst) rd_q <= 1'b0;
                else     rd_q <= hit.rd;
            end
            assign rd_pulse = rd_q;
        end else begin : g_no_rd
            logic unused_rd;
            assign unused_rd = hit.rd;
            assign rd_pulse  = 1'b0;
        end

        if (WR_NTF) begin : g_wr
            logic              wr_q;
            logic [DATA_W-1:0] data_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    wr_q   <= 1'b0;
                    data_q <= '0;
                end else begin
                    wr_q <= hit.wr;
                    if (hit.wr) data_q <= host_data;
                end
            end
            assign wr_pulse  = wr_q;
            assign wr_data_q = data_q;
        end else begin : g_no_wr
            logic unused_wr;
            assign unused_wr = hit.wr ^ (^host_data);
            assign wr_pulse  = 1'b0;
            assign wr_data_q = '0;
        end
    endgenerate

    logic unused_clk;
    assign unused_clk = clk ^ rst;

endmodule

// File: rtl/acc_reg_cell.sv
module acc_reg_cell
    import acc_reg_cell_pkg::*;
#(
    parameter int        DATA_W = 32,
    parameter acc_kind_e ACC    = ACC_HOST_RW,
    parameter logic [DATA_W-1:0] RST_VAL   = '0,
    parameter logic [DATA_W-1:0] CONST_VAL = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_stb,
    input  logic              rd_stb,
    input  logic              addr_hit,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              upd_stb,
    input  logic [DATA_W-1:0] upd_data,
    output logic [DATA_W-1:0] rd_value,
    output logic [DATA_W-1:0] value_out,
    output logic              rd_pulse,
    output logic              wr_pulse,
    output logic [DATA_W-1:0] wr_data_q
);

    localparam bit READABLE = acc_readable(ACC);

    hit_t hit;
    assign hit.wr = wr_stb & addr_hit;
    assign hit.rd = rd_stb & addr_hit;

    logic [DATA_W-1:0] held;

    acc_reg_store #(
        .DATA_W   (DATA_W),
        .ACC      (ACC),
        .RST_VAL  (RST_VAL),
        .CONST_VAL(CONST_VAL)
    ) u_store (
        .clk      (clk),
        .rst      (rst),
        .host_we  (hit.wr),
        .host_data(wr_data),
        .upd_stb  (upd_stb),
        .upd_data (upd_data),
        .value    (held)
    );

    acc_reg_notify #(
        .DATA_W(DATA_W),
        .ACC   (ACC)
    ) u_notify (
        .clk      (clk),
        .rst      (rst),
        .hit      (hit),
        .host_data(wr_data),
        .rd_pulse (rd_pulse),
        .wr_pulse (wr_pulse),
        .wr_data_q(wr_data_q)
    );

    assign value_out = held;

    generate
        if (READABLE) begin : g_rd_open
            assign rd_value = held;
        end else begin : g_rd_zero
            assign rd_value = '0;
        end
    endgenerate

endmodule

// File: rtl/acc_reg_cell_chk.sv
module acc_reg_cell_chk
    import acc_reg_cell_pkg::*;
#(
    parameter int        DATA_W = 32,
    parameter acc_kind_e ACC    = ACC_HOST_RW,
    parameter logic [DATA_W-1:0] CONST_VAL = '0
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_stb,
    input logic              rd_stb,
    input logic              addr_hit,
    input logic [DATA_W-1:0] wr_data,
    input logic              upd_stb,
    input logic [DATA_W-1:0] upd_data,
    input logic [DATA_W-1:0] rd_value,
    input logic [DATA_W-1:0] value_out,
    input logic              rd_pulse,
    input logic              wr_pulse,
    input logic [DATA_W-1:0] wr_data_q
);

    localparam owner_e OWNER = acc_owner(ACC);

    generate
        if (acc_wr_notify(ACC)) begin : g_wn
            p_wr_pulse_r4: assert property (@(posedge clk) disable iff (rst)
                !$past(rst) |-> (wr_pulse == $past(wr_stb && addr_hit)));
            p_wr_copy_r7: assert property (@(posedge clk) disable iff (rst)
                wr_pulse |-> (wr_data_q == $past(wr_data)));
        end else begin : g_nwn
            p_no_wr_pulse_r4: assert property (@(posedge clk) disable iff (rst)
                !wr_pulse);
        end

        if (acc_rd_notify(ACC)) begin : g_rn
            p_rd_pulse_r6: assert property (@(posedge clk) disable iff (rst)
                !$past(rst) |-> (rd_pulse == $past(rd_stb && addr_hit)));
        end else begin : g_nrn
            p_no_rd_pulse_r6: assert property (@(posedge clk) disable iff (rst)
                !rd_pulse);
        end

        if (OWNER == OWN_LOGIC) begin : g_lg
            p_logic_hold_r5: assert property (@(posedge clk) disable iff (rst)
                (!$past(rst) && !$past(upd_stb)) |-> $stable(value_out));
            p_logic_load_r10: assert property (@(posedge clk) disable iff (rst)
                (!$past(rst) && $past(upd_stb)) |-> (value_out == $past(upd_data)));
        end

        if (OWNER == OWN_HOST) begin : g_hs
            p_no_hit_hold_r2: assert property (@(posedge clk) disable iff (rst)
                (!$past(rst) && !$past(wr_stb && addr_hit)) |-> $stable(value_out));
            p_host_load_r1: assert property (@(posedge clk) disable iff (rst)
                (!$past(rst) && $past(wr_stb && addr_hit)) |-> (value_out == $past(wr_data)));
        end

        if (!acc_readable(ACC)) begin : g_wo
            p_wo_zero_r3: assert property (@(posedge clk) disable iff (rst)
                rd_value == '0);
        end else begin : g_rdable
            p_read_match_r5: assert property (@(posedge clk) disable iff (rst)
                rd_value == value_out);
        end

        if (OWNER == OWN_PARAM) begin : g_cst
            p_const_r8: assert property (@(posedge clk) disable iff (rst)
                (rd_value == CONST_VAL) && (value_out == CONST_VAL));
        end
    endgenerate

endmodule

bind acc_reg_cell acc_reg_cell_chk #(
    .DATA_W   (DATA_W),
    .ACC      (ACC),
    .CONST_VAL(CONST_VAL)
) u_chk (.*);

// File: tb/acc_reg_cell_bench.sv
`timescale 1ns/1ps
module acc_reg_cell_bench;
    import acc_reg_cell_pkg::*;

    localparam int W = 32;
    localparam logic [W-1:0] RK  = 32'h1234_5678;
    localparam logic [W-1:0] RRW = 32'hA5A5_0000;
    localparam logic [W-1:0] RWO = 32'h0000_00FF;
    localparam logic [W-1:0] CV  = 32'hC0DE_0042;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_stb = 1'b0, rd_stb = 1'b0, addr_hit = 1'b0, upd_stb = 1'b0;
    logic [W-1:0] wr_data = '0, upd_data = '0;

    always #2.5 clk = ~clk;

    logic [W-1:0] k_rd, k_val, k_wdq, rw_rd, rw_val, rw_wdq, wo_rd, wo_val, wo_wdq, c_rd, c_val, c_wdq;
    logic k_rdp, k_wrp, rw_rdp, rw_wrp, wo_rdp, wo_wrp, c_rdp, c_wrp;

    acc_reg_cell #(.DATA_W(W), .ACC(ACC_LOGIC_RO_RWNTF), .RST_VAL(RK)) u_acc_reg_cell (
        .clk(clk), .rst(rst), .wr_stb(wr_stb), .rd_stb(rd_stb), .addr_hit(addr_hit),
        .wr_data(wr_data), .upd_stb(upd_stb), .upd_data(upd_data),
        .rd_value(k_rd), .value_out(k_val), .rd_pulse(k_rdp), .wr_pulse(k_wrp), .wr_data_q(k_wdq));

    acc_reg_cell #(.DATA_W(W), .ACC(ACC_HOST_RW), .RST_VAL(RRW)) u_acc_reg_cell_rw (
        .clk(clk), .rst(rst), .wr_stb(wr_stb), .rd_stb(rd_stb), .addr_hit(addr_hit),
        .wr_data(wr_data), .upd_stb(upd_stb), .upd_data(upd_data),
        .rd_value(rw_rd), .value_out(rw_val), .rd_pulse(rw_rdp), .wr_pulse(rw_wrp), .wr_data_q(rw_wdq));

    acc_reg_cell #(.DATA_W(W), .ACC(ACC_HOST_WO_WNTF), .RST_VAL(RWO)) u_acc_reg_cell_wo (
        .clk(clk), .rst(rst), .wr_stb(wr_stb), .rd_stb(rd_stb), .addr_hit(addr_hit),
        .wr_data(wr_data), .upd_stb(upd_stb), .upd_data(upd_data),
        .rd_value(wo_rd), .value_out(wo_val), .rd_pulse(wo_rdp), .wr_pulse(wo_wrp), .wr_data_q(wo_wdq));

    acc_reg_cell #(.DATA_W(W), .ACC(ACC_CONST), .CONST_VAL(CV)) u_acc_reg_cell_c (
        .clk(clk), .rst(rst), .wr_stb(wr_stb), .rd_stb(rd_stb), .addr_hit(addr_hit),
        .wr_data(wr_data), .upd_stb(upd_stb), .upd_data(upd_data),
        .rd_value(c_rd), .value_out(c_val), .rd_pulse(c_rdp), .wr_pulse(c_wrp), .wr_data_q(c_wdq));

    typedef struct {
        int           due;
        int           fld;
        logic [W-1:0] exp;
        string        req;
    } item_t;

    item_t q[$];
    int cyc = 0;
    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // bench model state
    logic [W-1:0] mk = RK, mrw = RRW, mwo = RWO, mwdq_k = '0, mwdq_wo = '0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [W-1:0] actual(int f);
        case (f)
            0:  return k_rd;
            1:  return k_val;
            2:  return {31'd0, k_rdp};
            3:  return {31'd0, k_wrp};
            4:  return k_wdq;
            5:  return rw_rd;
            6:  return rw_val;
            7:  return {31'd0, rw_wrp};
            8:  return wo_rd;
            9:  return wo_val;
            10: return {31'd0, wo_wrp};
            11: return c_rd;
            12: return c_val;
            default: return wo_wdq;
        endcase
    endfunction

    task automatic push(int f, logic [W-1:0] e, string r);
        item_t it;
        it.due = cyc + 1;
        it.fld = f;
        it.exp = e;
        it.req = r;
        q.push_back(it);
    endtask

    // driver: one clock cycle of stimulus, expectations for the state after the edge
    task automatic step(bit r, bit w, bit rd, bit h, logic [W-1:0] d, bit u, logic [W-1:0] ud);
        bit wh, rh;
        string tk, thost, tw;
        @(negedge clk);
        rst = r; wr_stb = w; rd_stb = rd; addr_hit = h; wr_data = d;
        upd_stb = u; upd_data = ud;
        wh = w && h;
        rh = rd && h;
        if (r) begin
            mk = RK; mrw = RRW; mwo = RWO; mwdq_k = '0; mwdq_wo = '0;
            wh = 1'b0; rh = 1'b0;
            tk = "R9"; thost = "R9"; tw = "R9";
        end else begin
            if (u) mk = ud;
            if (wh) begin
                mrw = d; mwo = d; mwdq_k = d; mwdq_wo = d;
            end
            tk    = (u && wh) ? "R10" : (wh ? "R7" : (w ? "R2" : "R5"));
            thost = u ? "R11" : ((w && !h) ? "R2" : "R1");
            tw    = (u && wh) ? "R10" : ((w && !h) ? "R2" : "R4");
        end
        push(0,  mk, tk);
        push(1,  mk, tk);
        push(2,  {31'd0, rh}, r ? "R9" : "R6");
        push(3,  {31'd0, wh}, tw);
        push(4,  mwdq_k, r ? "R9" : (wh ? "R7" : "R2"));
        push(5,  mrw, thost);
        push(6,  mrw, thost);
        push(7,  '0, r ? "R9" : "R4");
        push(8,  '0, r ? "R9" : "R3");
        push(9,  mwo, r ? "R9" : (u ? "R11" : "R3"));
        push(10, {31'd0, wh}, tw);
        push(11, CV, "R8");
        push(12, CV, "R8");
        push(13, mwdq_wo, r ? "R9" : "R4");
    endtask

    // monitor / scoreboard
    initial begin
        forever begin
            @(posedge clk);
            #1;
            while (q.size() > 0 && q[0].due <= cyc) begin
                item_t it;
                logic [W-1:0] a;
                it = q.pop_front();
                a = actual(it.fld);
                n_cmp++;
                if (a !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s field %0d cycle %0d: actual %h expected %h",
                             it.req, it.fld, cyc, a, it.exp);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // R9 reset
        step(1, 0, 0, 0, '0, 0, '0);
        step(1, 1, 1, 1, 32'hFFFF_FFFF, 1, 32'hFFFF_FFFF);
        step(0, 0, 0, 0, '0, 0, '0);
        // R1 / R3 / R4 / R7 host write hit
        step(0, 1, 0, 1, 32'h1111_2222, 0, '0);
        step(0, 0, 1, 1, '0, 0, '0);            // R6 read hit
        step(0, 0, 1, 0, '0, 0, '0);            // read without hit
        // R2 write without hit
        step(0, 1, 0, 0, 32'hDEAD_0001, 0, '0);
        // R5 update alone, R11 on host types
        step(0, 0, 0, 0, '0, 1, 32'h0BAD_C0DE);
        step(0, 0, 0, 0, '0, 0, 32'h7777_7777);
        // R7 host write to logic cell, value held
        step(0, 1, 0, 1, 32'h3333_4444, 0, '0);
        // R10 same-cycle update and host write
        step(0, 1, 0, 1, 32'h5555_6666, 1, 32'h9999_AAAA);
        // back-to-back writes and reads
        step(0, 1, 1, 1, 32'h0000_0001, 0, '0);
        step(0, 1, 1, 1, 32'h8000_0000, 0, '0);
        step(0, 0, 0, 1, 32'hFFFF_FFFF, 0, '0);
        // update with a non-hit write
        step(0, 1, 0, 0, 32'h1234_0000, 1, 32'h0000_ABCD);
        // reset mid-run, then R3 write-only read stays zero after all-ones write
        step(1, 0, 0, 0, '0, 0, '0);
        step(0, 1, 1, 1, 32'hFFFF_FFFF, 0, '0);
        step(0, 0, 0, 0, '0, 0, '0);
        step(0, 0, 0, 0, '0, 0, '0);
        repeat (3) @(posedge clk);
        done = 1'b1;
        #2;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule